// File: doc/BRIEF.md
# Clock synthesizer lock status register

This block is the status word of a clock synthesizer. Software reads it to see four things. The first is whether the loop is locked at this moment. The second is whether lock has held since the last event that re-arms lock tracking. The third is whether a loss of clock has been seen. The fourth is which reference source the chip chose when it came out of reset. The lock and loss-of-clock indications from the analog loop are asynchronous, so each passes through a two-flop synchronizer before it reaches any status bit. The loss-of-clock flag is the block's interrupt request. Software clears it by writing a one to its bit position.

Four mode straps are sampled while reset is asserted: crystal, external clock, bypass and dual controller. In bypass mode the lock bits stay at zero.

The sticky lock bit is re-armed by any of three events:
- reset;
- a register write that changed the multiplier or predivider fields, which the surrounding logic flags;
- a modulation-enable pulse.

Once re-armed, the sticky bit goes to one the next time lock is seen. Any loss of lock pulls it back to zero. A relock alone does not bring it back.

Top module: `pll_stat_reg`

## Requirements
- R1: The reference bit (read bit 5) reads 1 when the strap sampled during reset was crystal (strap code 0). It reads 0 for external clock (code 1), bypass (code 2) and dual controller (code 3). It keeps that value until the next reset.
- R2: After reset the sticky lock bit (read bit 4) is 1 in crystal, external and dual-controller modes, and 0 in bypass mode. The live lock bit, the loss-of-clock flag and the interrupt request are 0.
- R3: Outside bypass mode, the live lock bit (read bit 3) follows the raw lock input after a two-flop synchronizer.
- R4: A 1-to-0 transition of the synchronized lock clears the sticky lock bit. The bit stays 0 across any later relock until a re-arming event occurs.
- R5: The sticky lock bit is set at the first synchronized lock seen at or after a re-arming event. The re-arming events are a write with the divider-change indication high, or a modulation-enable pulse. A write with the divider-change indication low does not re-arm.
- R6: In bypass mode the live lock bit and the sticky lock bit stay 0 whatever the lock input, writes or modulation pulses do.
- R7: The loss-of-clock flag (read bit 2) is set by a synchronized loss-of-clock pulse. It stays set after the clock returns.
- R8: A write with data bit 2 set clears the flag. A write with data bit 2 clear leaves it unchanged. If a synchronized loss-of-clock pulse is present in the same cycle as a clearing write, the flag stays set.
- R9: The interrupt request output equals the loss-of-clock flag.
- R10: Read bits 31 to 6 and 1 to 0 are always 0. The read word is registered, so it shows the status bits as they stood one cycle earlier. A change on the raw lock input driven before a clock edge first appears in the read word after the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_mode | input | 2 | Mode strap: 0 crystal, 1 external clock, 2 bypass, 3 dual controller |
| lock_raw | input | 1 | Asynchronous lock indication from the lock detector |
| loc_raw | input | 1 | Asynchronous loss-of-clock indication |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 2 set clears the loss-of-clock flag |
| wr_div_chg | input | 1 | The current write changed the multiplier or predivider fields |
| mod_en_evt | input | 1 | Frequency modulation was just enabled |
| rd_data | output | 32 | Registered status word |
| irq | output | 1 | Loss-of-clock interrupt request |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a loss-of-clock set and a write-one-to-clear of the same flag. The bench holds the raw loss-of-clock input high across several cycles and issues a clearing write in the middle of that window. The flag and the interrupt must still be set afterwards. The same write repeated after the input falls must clear them.

The second pair is a re-arming event and the lock state. The bench re-arms both while unlocked and while locked. It checks that the sticky bit rises only once lock is seen, and that a plain relock with no re-arming event leaves it at zero.

Every case is swept across all four strap modes.

// File: rtl/pll_stat_pkg.sv
package pll_stat_pkg;

    localparam int unsigned STAT_DATA_W  = 32;
    localparam int unsigned STAT_REF_POS = 5;
    localparam int unsigned STAT_STK_POS = 4;
    localparam int unsigned STAT_LCK_POS = 3;
    localparam int unsigned STAT_LOC_POS = 2;

    typedef enum logic [1:0] {
        MODE_CRYSTAL = 2'd0,
        MODE_EXTCLK  = 2'd1,
        MODE_BYPASS  = 2'd2,
        MODE_DUAL    = 2'd3
    } strap_mode_e;

    typedef struct packed {
        logic ref_xtal;
        logic bypass;
        logic sticky;
        logic armed;
        logic lock;
        logic lock_prev;
        logic loc_flag;
    } stat_state_t;

endpackage

// File: rtl/pll_stat_sync.sv
module pll_stat_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            if (!rst_n) begin
                chain_d = '0;
            end else if (STAGES > 1) begin
                chain_d = {chain_q[STAGES-2:0], async_in[b]};
            end else begin
                chain_d = async_in[b];
            end
        end

        always_ff @(posedge clk) begin
            chain_q <= chain_d;
        end

        assign sync_out[b] = chain_q[LAST];
    end

endmodule

// File: rtl/pll_stat_core.sv
module pll_stat_core
    import pll_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  strap_mode_e strap,
    input  logic        lock_s,
    input  logic        loc_s,
    input  logic        clr_req,
    input  logic        rearm_req,
    output stat_state_t st_q
);

    stat_state_t st_d;
    logic        lock_fall;
    logic        rearm_ok;

    always_comb begin
        st_d      = st_q;
        lock_fall = st_q.lock_prev & ~lock_s;
        rearm_ok  = rearm_req & ~st_q.bypass;
        if (!rst_n) begin
            st_d.ref_xtal  = (strap == MODE_CRYSTAL);
            st_d.bypass    = (strap == MODE_BYPASS);
            st_d.sticky    = (strap != MODE_BYPASS);
            st_d.armed     = 1'b0;
            st_d.lock      = 1'b0;
            st_d.lock_prev = 1'b0;
            st_d.loc_flag  = 1'b0;
        end else begin
            st_d.lock_prev = lock_s;
            st_d.lock      = lock_s & ~st_q.bypass;
            if (rearm_ok) begin
                st_d.armed = 1'b1;
            end
            if (lock_fall) begin
                st_d.sticky = 1'b0;
            end else if ((st_q.armed | rearm_ok) & lock_s & ~st_q.bypass) begin
                st_d.sticky = 1'b1;
                st_d.armed  = 1'b0;
            end
            if (loc_s) begin
                st_d.loc_flag = 1'b1;
            end else if (clr_req) begin
                st_d.loc_flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/pll_stat_rdword.sv
module pll_stat_rdword #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned REF_POS = 5,
    parameter int unsigned STK_POS = 4,
    parameter int unsigned LCK_POS = 3,
    parameter int unsigned LOC_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_bit,
    input  logic              stk_bit,
    input  logic              lck_bit,
    input  logic              loc_bit,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
        word_d = '0;
        if (rst_n) begin
            word_d[REF_POS] = ref_bit;
            word_d[STK_POS] = stk_bit;
            word_d[LCK_POS] = lck_bit;
            word_d[LOC_POS] = loc_bit;
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign rd_word = word_q;

endmodule

// File: rtl/pll_stat_reg.sv
module pll_stat_reg
    import pll_stat_pkg::*;
#(
    parameter int unsigned DATA_W      = STAT_DATA_W,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REF_POS     = STAT_REF_POS,
    parameter int unsigned STK_POS     = STAT_STK_POS,
    parameter int unsigned LCK_POS     = STAT_LCK_POS,
    parameter int unsigned LOC_POS     = STAT_LOC_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_mode,
    input  logic              lock_raw,
    input  logic              loc_raw,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_div_chg,
    input  logic              mod_en_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned N_ASYNC = 2;

    logic [N_ASYNC-1:0] raw_vec;
    logic [N_ASYNC-1:0] syn_vec;
    stat_state_t        st;
    logic               clr_req;
    logic               rearm_req;

    assign raw_vec   = {loc_raw, lock_raw};
    assign clr_req   = wr_en & wr_data[LOC_POS];
    assign rearm_req = (wr_en & wr_div_chg) | mod_en_evt;

    pll_stat_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_vec),
        .sync_out (syn_vec)
    );

    pll_stat_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap_mode_e'(strap_mode)),
        .lock_s    (syn_vec[0]),
        .loc_s     (syn_vec[1]),
        .clr_req   (clr_req),
        .rearm_req (rearm_req),
        .st_q      (st)
    );

    pll_stat_rdword #(
        .DATA_W  (DATA_W),
        .REF_POS (REF_POS),
        .STK_POS (STK_POS),
        .LCK_POS (LCK_POS),
        .LOC_POS (LOC_POS)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_bit (st.ref_xtal),
        .stk_bit (st.sticky),
        .lck_bit (st.lock),
        .loc_bit (st.loc_flag),
        .rd_word (rd_data)
    );

    assign irq = st.loc_flag;

endmodule

// File: rtl/pll_stat_reg_chk.sv
module pll_stat_reg_chk
    import pll_stat_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             strap_mode,
    input logic                   wr_en,
    input logic [STAT_DATA_W-1:0] wr_data,
    input logic [STAT_DATA_W-1:0] rd_data,
    input logic                   irq
);

    localparam logic [STAT_DATA_W-1:0] USED_MASK =
        (STAT_DATA_W'(1) << STAT_REF_POS) | (STAT_DATA_W'(1) << STAT_STK_POS) |
        (STAT_DATA_W'(1) << STAT_LCK_POS) | (STAT_DATA_W'(1) << STAT_LOC_POS);

    logic [1:0] cyc_q;
    logic       byp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            byp_q <= (strap_mode == MODE_BYPASS);
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    // R1: reference bit does not move once the read word has settled
    p_ref_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> $stable(rd_data[STAT_REF_POS]));

    // R6: bypass keeps both lock bits low
    p_bypass_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q && cyc_q != 2'd0) |-> (!rd_data[STAT_LCK_POS] && !rd_data[STAT_STK_POS]));

    // R7: the flag holds when no write occurs
    p_loc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);

    // R8: writing 0 at the flag position leaves it set
    p_w0_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && wr_en && !wr_data[STAT_LOC_POS]) |=> irq);

    // R9: read word shows the interrupt flag one cycle late
    p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0) |-> (rd_data[STAT_LOC_POS] == $past(irq)));

    // R10: spare bits read zero
    p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED_MASK) == '0);

endmodule

bind pll_stat_reg pll_stat_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_mode (strap_mode),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/pll_stat_reg_bench.sv
module pll_stat_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  strap_mode;
    logic        lock_raw;
    logic        loc_raw;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        wr_div_chg;
    logic        mod_en_evt;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_stat_reg u_pll_stat_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_mode (strap_mode),
        .lock_raw   (lock_raw),
        .loc_raw    (loc_raw),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_div_chg (wr_div_chg),
        .mod_en_evt (mod_en_evt),
        .rd_data    (rd_data),
        .irq        (irq)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        rst_n = 1'b0; strap_mode = mode;
        lock_raw = 1'b0; loc_raw = 1'b0;
        wr_en = 1'b0; wr_data = '0; wr_div_chg = 1'b0; mod_en_evt = 1'b0;
        tick(3);
        rst_n = 1'b1;
        strap_mode = ~mode;
        tick(3);
    endtask

    task automatic do_write(input logic [31:0] d, input logic div);
        wr_en = 1'b1; wr_data = d; wr_div_chg = div;
        tick(1);
        wr_en = 1'b0; wr_data = '0; wr_div_chg = 1'b0;
    endtask

    task automatic pulse_mod();
        mod_en_evt = 1'b1;
        tick(1);
        mod_en_evt = 1'b0;
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            logic [1:0] mode;
            logic       byp;
            logic       refx;
            mode = 2'(m);
            byp  = (mode == 2'd2);
            refx = (mode == 2'd0);
            do_reset(mode);

            // R2, R1, R10: reset state
            chk("R1",  "ref bit after reset", 32'(rd_data[5]), 32'(refx));
            chk("R2",  "sticky after reset", 32'(rd_data[4]), 32'(!byp));
            chk("R2",  "lock after reset", 32'(rd_data[3]), 32'd0);
            chk("R2",  "irq after reset", 32'(irq), 32'd0);
            chk("R10", "spare bits", rd_data & ~32'h3C, 32'd0);

            // R3, R10: lock latency, four rising edges to the read word
            lock_raw = 1'b1;
            tick(3);
            chk("R10", "lock not yet visible after 3 edges", 32'(rd_data[3]), 32'd0);
            tick(1);
            chk("R3",  "lock visible after 4 edges", 32'(rd_data[3]), 32'(!byp));
            tick(2);
            chk("R2",  "sticky kept while locked", 32'(rd_data[4]), 32'(!byp));

            // R4: loss clears, relock does not restore
            lock_raw = 1'b0;
            tick(SETTLE);
            chk("R3", "lock low after drop", 32'(rd_data[3]), 32'd0);
            chk("R4", "sticky cleared by loss", 32'(rd_data[4]), 32'd0);
            lock_raw = 1'b1;
            tick(SETTLE);
            chk("R4", "sticky stays low after relock", 32'(rd_data[4]), 32'd0);
            chk("R6", "lock bit vs bypass", 32'(rd_data[3]), 32'(!byp));

            // R5: a write without divider change does not re-arm
            do_write(32'h0000_0030, 1'b0);
            tick(SETTLE);
            chk("R5", "plain write no rearm", 32'(rd_data[4]), 32'd0);

            // R5: divider rewrite while locked re-arms
            do_write(32'h0000_0000, 1'b1);
            tick(SETTLE);
            chk("R5", "divider write rearms", 32'(rd_data[4]), 32'(!byp));

            // R5: modulation enable while unlocked waits for lock
            lock_raw = 1'b0;
            tick(SETTLE);
            chk("R4", "sticky cleared again", 32'(rd_data[4]), 32'd0);
            pulse_mod();
            tick(SETTLE);
            chk("R5", "rearm while unlocked holds 0", 32'(rd_data[4]), 32'd0);
            lock_raw = 1'b1;
            tick(SETTLE);
            chk("R5", "sticky set on lock after mod enable", 32'(rd_data[4]), 32'(!byp));
            chk("R6", "lock bit after relock", 32'(rd_data[3]), 32'(!byp));

            // R7: single loss-of-clock pulse sets flag, flag persists
            loc_raw = 1'b1;
            tick(1);
            loc_raw = 1'b0;
            tick(SETTLE);
            chk("R7", "flag set by pulse", 32'(rd_data[2]), 32'd1);
            chk("R9", "irq follows flag", 32'(irq), 32'd1);

            // R8: write zero keeps, write one clears
            do_write(32'hFFFF_FFFB, 1'b0);
            tick(SETTLE);
            chk("R8", "write 0 keeps flag", 32'(irq), 32'd1);
            do_write(32'h0000_0004, 1'b0);
            tick(SETTLE);
            chk("R8", "write 1 clears flag", 32'(rd_data[2]), 32'd0);
            chk("R9", "irq cleared", 32'(irq), 32'd0);

            // R8: clear during active loss-of-clock, set wins
            loc_raw = 1'b1;
            tick(SETTLE);
            do_write(32'h0000_0004, 1'b0);
            tick(1);
            chk("R8", "set wins over clear", 32'(irq), 32'd1);
            loc_raw = 1'b0;
            tick(SETTLE);
            chk("R7", "flag kept after clock returns", 32'(rd_data[2]), 32'd1);
            do_write(32'h0000_0004, 1'b0);
            tick(SETTLE);
            chk("R8", "clear after loss gone", 32'(irq), 32'd0);

            // R1: reference bit unchanged at end of run
            chk("R1", "ref bit held", 32'(rd_data[5]), 32'(refx));
            chk("R10", "spare bits at end", rd_data & ~32'h3C, 32'd0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule